// File: doc/BRIEF.md
# Cache Hit/Miss Profiling Counter Bank

This block keeps event counts for profiling a cache. Every access the cache has resolved arrives as a one-cycle strobe carrying three attribute bits: which address region was accessed (on-chip flash or external execute-in-place memory), whether the access was an instruction fetch or a data fetch, and whether it hit or missed. The block steers each strobe into one of eight counters: four per region, covering instruction hits, instruction misses, data hits and data misses. The hit decision and the region classification are made outside.

Software or a debug agent turns counting on with a level enable and zeroes all counters with a one-cycle clear command. Any counter is read through a small read port with one cycle of latency. Each counter stops at its largest value instead of wrapping, so a long profiling run cannot show a small count that has quietly wrapped around. When counting is switched off, the counts are kept and can still be read.

Top module: `prof_counter_bank`

## Requirements
- R1: A counter is selected by a 3-bit index formed as {region, is_data, is_miss}. Index 0 is flash instruction hits, 1 is flash instruction misses, 2 is flash data hits, 3 is flash data misses, and 4 to 7 are the same four kinds for the execute-in-place region (region bit = 1). Each accepted strobe adds one to the counter named by its index.
- R2: The two regions have independent counters. Events in one region never change any counter of the other region.
- R3: While `prof_enable` is low, strobes change no counter.
- R4: A cycle with `clear_pulse` high sets every counter to zero from the next cycle on.
- R5: When `clear_pulse` and an accepted strobe occur in the same cycle, the clear wins, and the addressed counter reads zero afterwards.
- R6: A counter at its all-ones value stays there when further strobes arrive. It does not wrap.
- R7: Dropping `prof_enable` keeps all counter values, and they remain readable through the read port.
- R8: A read request (`rd_en` high with `rd_index`) produces `rd_valid` high and `rd_data` in the next cycle. The value returned is the counter as it stood before any strobe accepted in the request cycle.
- R9: After reset every counter reads zero and `rd_valid` is low.
- R10: A cycle with `evt_valid` low changes no counter. An accepted strobe raises exactly one counter by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | One-cycle access event strobe |
| evt_region | input | REGION_W (1) | Region of the access: 0 is flash, 1 is execute-in-place |
| evt_is_data | input | 1 | 1 for a data fetch, 0 for an instruction fetch |
| evt_is_miss | input | 1 | 1 for a miss, 0 for a hit |
| prof_enable | input | 1 | Counting enable (level) |
| clear_pulse | input | 1 | Zeroes all counters |
| rd_en | input | 1 | Read request |
| rd_index | input | IDX_W (3) | Counter index to read, encoded as in R1 |
| rd_data | output | CNT_W (32) | Counter value read |
| rd_valid | output | 1 | rd_data holds a result |

## Verification
The bench aims at the places where a wrong design stays quiet. A clear that arrives together with an event is checked, because a design that gives the increment priority would leave a count of one. A second, 4-bit-wide instance is pushed past its all-ones value: a wrapping counter would read a small number there and disagree with the capped expectation. A read that lands in the same cycle as an event must return the value from before that event, which exposes a read path taken after the update. Strobes sent while counting is disabled, and strobes with the valid bit low but attribute bits set, must leave every counter unchanged, and events in one region must leave the other region's counters untouched; a bad index decode or gating would show up as stray counts in these reads.

// File: rtl/prof_pkg.sv
package prof_pkg;
   // counter kinds inside one region; the encoding is the low two index bits
   localparam int KINDS_PER_REGION = 4;
   localparam int KIND_W           = 2;

   typedef enum logic [KIND_W-1:0] {
      KIND_IHIT  = 2'd0,
      KIND_IMISS = 2'd1,
      KIND_DHIT  = 2'd2,
      KIND_DMISS = 2'd3
   } prof_kind_e;

   function automatic prof_kind_e kind_of(input logic is_data, input logic is_miss);
      return prof_kind_e'({is_data, is_miss});
   endfunction
endpackage

// File: rtl/prof_counter_cell.sv
module prof_counter_cell #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic at_max;
   assign at_max = (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc && !at_max) begin
         cnt <= cnt + CNT_ONE;
      end
   end
endmodule

// File: rtl/prof_event_decode.sv
module prof_event_decode
   import prof_pkg::*;
#(
   parameter int NUM_REGIONS = 2,
   parameter int REGION_W    = 1,
   parameter int IDX_W       = 3,
   parameter int NUM_CNT     = 8
) (
   input  logic                evt_valid,
   input  logic [REGION_W-1:0] evt_region,
   input  logic                evt_is_data,
   input  logic                evt_is_miss,
   input  logic                count_en,
   output logic [NUM_CNT-1:0]  inc_vec
);
   logic             region_ok;
   logic             accept;
   prof_kind_e       kind;
   logic [IDX_W-1:0] sel;

   // a region code past the last region is dropped; a full power of two needs no check
   generate
      if (NUM_REGIONS == (1 << REGION_W)) begin : g_region_full
         assign region_ok = 1'b1;
      end else begin : g_region_part
         assign region_ok = (int'(evt_region) < NUM_REGIONS);
      end
   endgenerate

   assign kind   = kind_of(evt_is_data, evt_is_miss);
   assign sel    = {evt_region, kind};
   assign accept = evt_valid && count_en && region_ok;

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_inc
         assign inc_vec[i] = accept && (sel == IDX_W'(i));
      end
   endgenerate
endmodule

// File: rtl/prof_read_port.sv
module prof_read_port #(
   parameter int CNT_W    = 32,
   parameter int NUM_CNT  = 8,
   parameter int IDX_W    = 3,
   parameter bit READ_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [IDX_W-1:0]         rd_index,
   input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
   output logic [CNT_W-1:0]         rd_data,
   output logic                     rd_valid
);
   logic [CNT_W-1:0] pick;

   always_comb begin
      pick = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (rd_index == IDX_W'(i)) begin
            pick = cnt_flat[i*CNT_W +: CNT_W];
         end
      end
   end

   generate
      if (READ_REG) begin : g_reg_read
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data  <= '0;
               rd_valid <= 1'b0;
            end else begin
               rd_valid <= rd_en;
               if (rd_en) begin
                  rd_data <= pick;
               end
            end
         end
      end else begin : g_comb_read
         assign rd_data  = rd_en ? pick : '0;
         assign rd_valid = rd_en;
      end
   endgenerate
endmodule

// File: rtl/prof_counter_bank.sv
module prof_counter_bank
   import prof_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int NUM_REGIONS = 2,
   parameter bit READ_REG    = 1'b1,
   localparam int REGION_W   = $clog2(NUM_REGIONS),
   localparam int IDX_W      = REGION_W + KIND_W,
   localparam int NUM_CNT    = NUM_REGIONS * KINDS_PER_REGION
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_valid,
   input  logic [REGION_W-1:0] evt_region,
   input  logic                evt_is_data,
   input  logic                evt_is_miss,
   input  logic                prof_enable,
   input  logic                clear_pulse,
   input  logic                rd_en,
   input  logic [IDX_W-1:0]    rd_index,
   output logic [CNT_W-1:0]    rd_data,
   output logic                rd_valid
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("prof_counter_bank: CNT_W must lie in 2..64");
      end
      if (NUM_REGIONS < 2 || NUM_REGIONS > 16) begin : g_bad_regions
         $error("prof_counter_bank: NUM_REGIONS must lie in 2..16");
      end
   endgenerate

   logic [NUM_CNT-1:0]       inc_vec;
   logic [NUM_CNT*CNT_W-1:0] cnt_flat;

   prof_event_decode #(
      .NUM_REGIONS (NUM_REGIONS),
      .REGION_W    (REGION_W),
      .IDX_W       (IDX_W),
      .NUM_CNT     (NUM_CNT)
   ) decode_i (
      .evt_valid   (evt_valid),
      .evt_region  (evt_region),
      .evt_is_data (evt_is_data),
      .evt_is_miss (evt_is_miss),
      .count_en    (prof_enable),
      .inc_vec     (inc_vec)
   );

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cell
         prof_counter_cell #(
            .CNT_W (CNT_W)
         ) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear_pulse),
            .inc   (inc_vec[i]),
            .cnt   (cnt_flat[i*CNT_W +: CNT_W])
         );
      end
   endgenerate

   prof_read_port #(
      .CNT_W    (CNT_W),
      .NUM_CNT  (NUM_CNT),
      .IDX_W    (IDX_W),
      .READ_REG (READ_REG)
   ) rdport_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_index (rd_index),
      .cnt_flat (cnt_flat),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );
endmodule

// File: rtl/prof_counter_bank_chk.sv
module prof_counter_bank_chk #(
   parameter int CNT_W    = 32,
   parameter int NUM_CNT  = 8,
   parameter bit READ_REG = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     prof_enable,
   input logic                     clear_pulse,
   input logic                     rd_en,
   input logic                     rd_valid,
   input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
   localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   // R4: a clear leaves every counter at zero
   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear_pulse |=> (cnt_flat == '0));

   // R3: with counting off and no clear, nothing moves
   assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!prof_enable && !clear_pulse) |=> $stable(cnt_flat));

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         // R6: a full counter stays full
         assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_flat[i*CNT_W +: CNT_W] == C_MAX) && !clear_pulse)
               |=> (cnt_flat[i*CNT_W +: CNT_W] == C_MAX));
         // R10: without clear a counter holds or steps by exactly one
         assert_unit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !clear_pulse |=>
               ((cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W])) ||
                (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) + C_ONE)));
      end

      if (READ_REG) begin : g_rd
         // R8: a read answers in the following cycle, and only then
         assert_rd_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> rd_valid);
         assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> !rd_valid);
      end
   endgenerate
endmodule

bind prof_counter_bank prof_counter_bank_chk #(
   .CNT_W    (CNT_W),
   .NUM_CNT  (NUM_CNT),
   .READ_REG (READ_REG)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .prof_enable (prof_enable),
   .clear_pulse (clear_pulse),
   .rd_en       (rd_en),
   .rd_valid    (rd_valid),
   .cnt_flat    (cnt_flat)
);

// File: tb/prof_counter_bank_tb_top.sv
module prof_counter_bank_tb_top;
   localparam int CLK_PERIOD_NS = 10;
   localparam int SAT_W         = 4;
   localparam longint SAT_MAX   = (64'd1 << SAT_W) - 1;

   logic clk = 1'b0;
   always #(CLK_PERIOD_NS/2) clk = ~clk;

   logic             rst_n;
   logic             evt_valid, evt_region, evt_is_data, evt_is_miss;
   logic             prof_enable, clear_pulse, rd_en;
   logic [2:0]       rd_index;
   logic [31:0]      rd_data;
   logic             rd_valid;
   logic [SAT_W-1:0] sat_data;
   logic             sat_valid;

   prof_counter_bank dut_i (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_region(evt_region),
      .evt_is_data(evt_is_data), .evt_is_miss(evt_is_miss), .prof_enable(prof_enable),
      .clear_pulse(clear_pulse), .rd_en(rd_en), .rd_index(rd_index),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // narrow copy on the same stimulus so saturation is reachable
   prof_counter_bank #(.CNT_W(SAT_W)) dut_sat_i (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_region(evt_region),
      .evt_is_data(evt_is_data), .evt_is_miss(evt_is_miss), .prof_enable(prof_enable),
      .clear_pulse(clear_pulse), .rd_en(rd_en), .rd_index(rd_index),
      .rd_data(sat_data), .rd_valid(sat_valid)
   );

   typedef struct {
      longint exp;
      string  tag;
   } rd_item_t;

   rd_item_t q[$];
   longint   model [8];
   string    tag_cur;
   int       checks = 0;
   int       fails  = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the expected item for every answered read
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (q.size() == 0) begin
            check(1'b0, "R8 unexpected rd_valid", 1, 0);
         end else begin
            rd_item_t it;
            longint   sat_exp;
            it      = q.pop_front();
            sat_exp = (it.exp > SAT_MAX) ? SAT_MAX : it.exp;
            check(longint'(rd_data) == it.exp, it.tag, longint'(rd_data), it.exp);
            check(sat_valid && (longint'(sat_data) == sat_exp),
                  {it.tag, " narrow"}, longint'(sat_data), sat_exp);
         end
      end
   end

   // one cycle of stimulus; called and returning at a falling edge
   task automatic step(input bit v, input bit r, input bit d, input bit m,
                       input bit clr, input bit rd, input int ridx);
      rd_item_t it;
      evt_valid   = v;
      evt_region  = r;
      evt_is_data = d;
      evt_is_miss = m;
      clear_pulse = clr;
      rd_en       = rd;
      rd_index    = 3'(ridx);
      if (rd) begin
         it.exp = model[ridx];
         it.tag = tag_cur;
         q.push_back(it);
      end
      if (clr) begin
         foreach (model[k]) model[k] = 0;
      end else if (v && prof_enable) begin
         model[int'({r, d, m})]++;
      end
      @(posedge clk);
      @(negedge clk);
      evt_valid   = 1'b0;
      clear_pulse = 1'b0;
      rd_en       = 1'b0;
   endtask

   task automatic ev(input int idx, input int n);
      for (int k = 0; k < n; k++) step(1'b1, idx[2], idx[1], idx[0], 1'b0, 1'b0, 0);
   endtask

   task automatic rd(input int idx);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, idx);
   endtask

   task automatic rd_all();
      for (int k = 0; k < 8; k++) rd(k);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
   endtask

   initial begin
      #(CLK_PERIOD_NS * 200000);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      foreach (model[k]) model[k] = 0;
      rst_n = 1'b0; evt_valid = 1'b0; evt_region = 1'b0; evt_is_data = 1'b0;
      evt_is_miss = 1'b0; prof_enable = 1'b0; clear_pulse = 1'b0; rd_en = 1'b0;
      rd_index = '0;
      repeat (3) @(negedge clk);
      check(!rd_valid && !sat_valid, "R9 rd_valid in reset", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      tag_cur = "R9 zero after reset";
      rd_all();

      // R1: distinct counts per index expose any decode swap
      prof_enable = 1'b1;
      for (int i = 0; i < 8; i++) ev(i, i + 1);
      tag_cur = "R1 index encoding";
      rd_all();

      // R2: execute-in-place data hits only
      ev(6, 5);
      tag_cur = "R2 region independence";
      rd(2); rd(6); rd(3); rd(7);

      // R10: attribute bits set but valid low
      for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
      tag_cur = "R10 valid low ignored";
      rd(5); rd(0);

      // R3 and R7: disabled strobes ignored, values kept and readable
      prof_enable = 1'b0;
      ev(1, 4);
      ev(4, 2);
      tag_cur = "R3 disabled strobes";
      rd(1); rd(4);
      tag_cur = "R7 values kept while disabled";
      rd_all();

      // R8: read in the same cycle as an event returns the old value
      prof_enable = 1'b1;
      tag_cur = "R8 read before same-cycle update";
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0);
      tag_cur = "R8 read after update";
      rd(0);

      // R5: clear together with an event
      tag_cur = "R5 clear wins";
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
      rd(7); rd_all();

      // R4: plain clear after some counts
      ev(3, 2); ev(4, 1);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
      tag_cur = "R4 clear zeroes all";
      rd_all();

      // R6: drive past the narrow instance's all-ones value
      ev(5, 20);
      tag_cur = "R6 saturate not wrap";
      rd(5);
      ev(5, 3);
      rd(5);

      idle(3);
      check(q.size() == 0, "R8 reads left unanswered", q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule